// File: doc/BRIEF.md
# Write-Back Dirty Tracking and Snoop Controller

This block holds the coherency state of a write-back cache whose lines are 16 bytes, split into four 4-byte doublewords. Each line has a valid bit and one modified flag per doubleword. Core stores set the flags of the doublewords they touch. Whenever data must leave the cache, only the flagged doublewords are sent out, one memory write per doubleword. Memory writes use a request/acknowledge handshake.

Tag comparison is done elsewhere and arrives as a hit flag plus a line slot number. The block answers four kinds of external request. An inquiry probe from another bus master can signal a hit on modified data. The modified data is then written out only after the master drops its hold request. A snooped bus-master write that hits simply discards the line. A core can also ask for a single line to be evicted, or for the whole cache to be flushed.

An optional flush-before-grant mode cleans the whole cache before hold acknowledge is given. A `busy` output tells the core to stall stores and fills while a sequence is running.

Top module: `cdt_snoop_ctrl`

## Requirements
- R1: A core store (`cw_valid`) to a valid line ORs `cw_mask` into that line's modified flags; bit i of the mask and of `qry_mod` stands for doubleword i. A store to an invalid line changes nothing. A fill makes the line valid with all flags clear.
- R2: A writeback issues one `wr_req` per flagged doubleword, in ascending doubleword index, and never one for a clean doubleword. Each request is held until `wr_ack`, and that doubleword's flag clears when the acknowledge is taken.
- R3: An inquiry that misses, or that hits a line with no flag set, leaves the controller idle in the next cycle, with no `wr_req` and no `hit_mod`. If the invalidate qualifier is set on a clean hit, the line reads invalid in the next cycle. A miss never touches any line.
- R4: An inquiry that hits a line with any flag set raises `hit_mod` in the next cycle. `hit_mod` stays high until the last flagged doubleword of that line has been acknowledged.
- R5: No snoop writeback starts while `hold_req` is high. The first `wr_req` appears in the cycle after `hold_req` is seen low.
- R6: After a snoop writeback the line is invalid if the invalidate qualifier was set, and otherwise valid with all flags clear.
- R7: A bus-master write (`bmw_valid` with `bmw_hit`) invalidates the hit line in the next cycle, with no `wr_req`, even when the line holds modified data.
- R8: With `fbg_mode` low, `hold_ack` rises in the cycle after `hold_req` is seen while the controller is idle, and falls in the cycle after `hold_req` drops. With `fbg_mode` high, a hold request first writes back every flagged line in ascending slot order. Lines stay valid, and `hold_ack` stays low until the last write has been acknowledged. `hold_ack` and `wr_req` are never high together.
- R9: A flush request writes back every flagged doubleword of every line in ascending slot order. Only after that are all lines invalidated, so no line turns invalid while flush writes are still pending.
- R10: An eviction request writes back the flagged doublewords of the named line and then invalidates it. An eviction of a clean line invalidates it in the next cycle with no write.
- R11: `busy` is high whenever a sequence is in progress. Core stores and fills presented while `busy` is high have no effect.
- R12: After reset every line is invalid and clean, and `busy`, `hold_ack`, `hit_mod` and `wr_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cw_valid | input | 1 | Core store strobe |
| cw_slot | input | SLOT_W | Line slot of the core store |
| cw_mask | input | DWS | Doublewords touched by the store |
| fill_valid | input | 1 | Line fill completed strobe |
| fill_slot | input | SLOT_W | Line slot being filled |
| inq_strobe | input | 1 | Inquiry address strobe |
| inq_inval | input | 1 | Invalidate qualifier of the inquiry |
| inq_hit | input | 1 | Tag hit for the inquiry address |
| inq_slot | input | SLOT_W | Line slot hit by the inquiry |
| bmw_valid | input | 1 | Snooped bus-master write strobe |
| bmw_hit | input | 1 | Tag hit for the bus-master write |
| bmw_slot | input | SLOT_W | Line slot hit by the bus-master write |
| evict_req | input | 1 | Evict-line request |
| evict_slot | input | SLOT_W | Line slot to evict |
| flush_req | input | 1 | Whole-cache flush request |
| fbg_mode | input | 1 | Flush-before-grant mode select |
| hold_req | input | 1 | Bus hold request from another master |
| hold_ack | output | 1 | Hold acknowledge |
| hit_mod | output | 1 | Inquiry hit modified data |
| wr_req | output | 1 | Memory write request |
| wr_slot | output | SLOT_W | Line slot of the write |
| wr_dw | output | DW_W | Doubleword index of the write |
| wr_ack | input | 1 | Memory write acknowledge |
| busy | output | 1 | Sequence in progress; core must stall |
| qry_slot | input | SLOT_W | Line slot to observe |
| qry_valid | output | 1 | Valid bit of the observed line |
| qry_mod | output | DWS | Modified flags of the observed line |

## Verification
The assertions assume several things about the inputs. Inquiries, bus-master writes, evictions and flushes are only presented while `busy` is low. `wr_ack` is only raised while `wr_req` is high. The tag interface reports a hit only for slots that were filled. The bench keeps to these rules: it starts every sequence from idle and waits for `busy` to fall before the next one. Its memory model acknowledges only a pending request, either every cycle or every other cycle. Hit slots come from lines the bench itself filled. Core stores during a sequence are presented on purpose, to show they are ignored.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SNP_WAIT,
    ST_WB_LINE,
    ST_SWEEP
  } cdt_state_e;

  typedef enum logic [1:0] {
    OP_SNOOP,
    OP_EVICT,
    OP_HOLD_SWEEP,
    OP_FLUSH
  } cdt_op_e;

  // Index of the lowest set bit; zero when the mask is empty.
  function automatic logic [3:0] lowest_dw(input logic [15:0] mask);
    logic [3:0] idx;
    idx = '0;
    for (int i = 15; i >= 0; i--) begin
      if (mask[i]) idx = 4'(i);
    end
    return idx;
  endfunction

  // True when the mask has at most the given bit set.
  function automatic logic only_bit_left(input logic [15:0] mask, input logic [3:0] idx);
    logic [15:0] rest;
    rest = mask & ~(16'd1 << idx);
    return (rest == 16'd0);
  endfunction

endpackage

// File: rtl/cdt_line_state.sv
module cdt_line_state #(
  parameter int LINES  = 8,
  parameter int DWS    = 4,
  parameter int SLOT_W = $clog2(LINES),
  parameter int DW_W   = $clog2(DWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cw_en,
  input  logic [SLOT_W-1:0] cw_slot,
  input  logic [DWS-1:0]    cw_mask,
  input  logic              fill_en,
  input  logic [SLOT_W-1:0] fill_slot,
  input  logic              inv_en,
  input  logic [SLOT_W-1:0] inv_slot,
  input  logic              inv_all,
  input  logic              clr_en,
  input  logic [SLOT_W-1:0] clr_slot,
  input  logic [DW_W-1:0]   clr_dw,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [DWS-1:0]    rd_mod,
  input  logic [SLOT_W-1:0] qry_slot,
  output logic              qry_valid,
  output logic [DWS-1:0]    qry_mod,
  output logic [LINES-1:0]  line_dirty,
  output logic              any_dirty
);

  logic [LINES-1:0] valid_q;
  logic [DWS-1:0]   mod_q [LINES];
  logic [DWS-1:0]   clr_bit;

  assign clr_bit = DWS'(1) << clr_dw;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic           sel_cw, sel_fill, sel_inv, sel_clr;
    logic [DWS-1:0] mod_nx;

    assign sel_cw   = cw_en   && (cw_slot   == SLOT_W'(g));
    assign sel_fill = fill_en && (fill_slot == SLOT_W'(g));
    assign sel_inv  = inv_all || (inv_en && (inv_slot == SLOT_W'(g)));
    assign sel_clr  = clr_en  && (clr_slot  == SLOT_W'(g));

    always_comb begin
      mod_nx = mod_q[g];
      if (sel_clr) mod_nx = mod_nx & ~clr_bit;
      if (sel_cw && valid_q[g]) mod_nx = mod_nx | cw_mask;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        mod_q[g]   <= '0;
      end else if (sel_inv) begin
        valid_q[g] <= 1'b0;
        mod_q[g]   <= '0;
      end else if (sel_fill) begin
        valid_q[g] <= 1'b1;
        mod_q[g]   <= '0;
      end else begin
        mod_q[g]   <= mod_nx;
      end
    end

    assign line_dirty[g] = |mod_q[g];

    // R1: modified flags only ever live on a valid line
    p_mod_needs_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
      line_dirty[g] |-> valid_q[g]);
  end

  assign any_dirty = |line_dirty;
  assign rd_mod    = mod_q[rd_slot];
  assign qry_valid = valid_q[qry_slot];
  assign qry_mod   = mod_q[qry_slot];

  // R2: the sequencer only retires doublewords that are flagged
  p_clear_only_dirty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> mod_q[clr_slot][clr_dw]);

  // R9: global invalidation only once nothing is left to write
  p_flush_after_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |-> !any_dirty);

endmodule

// File: rtl/cdt_hold_arb.sv
module cdt_hold_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req,
  input  logic fbg_mode,
  input  logic seq_idle,
  input  logic any_dirty,
  output logic hold_ack,
  output logic sweep_start
);

  logic grant_ok;
  logic hold_ack_d;

  // Grant once idle; in flush-before-grant mode also wait for a clean cache.
  assign grant_ok    = seq_idle && (!fbg_mode || !any_dirty);
  assign hold_ack_d  = hold_req && (hold_ack || grant_ok);
  assign sweep_start = hold_req && fbg_mode && any_dirty && !hold_ack && seq_idle;

  always_ff @(posedge clk) begin
    if (!rst_n) hold_ack <= 1'b0;
    else        hold_ack <= hold_ack_d;
  end

  // R8: acknowledge only follows a request seen in the previous cycle
  p_ack_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> $past(hold_req));

  // R8: in flush-before-grant mode the grant finds no modified data
  p_fbg_clean_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack) |-> $past(!fbg_mode || !any_dirty));

endmodule

// File: rtl/cdt_wb_seq.sv
module cdt_wb_seq
  import cdt_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int DWS    = 4,
  parameter int SLOT_W = $clog2(LINES),
  parameter int DW_W   = $clog2(DWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inq_strobe,
  input  logic              inq_inval,
  input  logic              inq_hit,
  input  logic [SLOT_W-1:0] inq_slot,
  input  logic              bmw_valid,
  input  logic              bmw_hit,
  input  logic [SLOT_W-1:0] bmw_slot,
  input  logic              evict_req,
  input  logic [SLOT_W-1:0] evict_slot,
  input  logic              flush_req,
  input  logic              hold_req,
  input  logic              sweep_start,
  input  logic [LINES-1:0]  line_dirty,
  input  logic [DWS-1:0]    rd_mod,
  input  logic              wr_ack,
  output logic              seq_idle,
  output logic [SLOT_W-1:0] cur_slot,
  output logic              inv_en,
  output logic [SLOT_W-1:0] inv_slot,
  output logic              inv_all,
  output logic              clr_en,
  output logic [DW_W-1:0]   clr_dw,
  output logic              wr_req,
  output logic [DW_W-1:0]   wr_dw,
  output logic              hit_mod,
  output logic              busy
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(LINES - 1);

  cdt_state_e        state_q, state_d;
  cdt_op_e           op_q, op_d;
  logic              inval_q, inval_d;
  logic [SLOT_W-1:0] cur_d;
  logic              line_done;
  logic              op_is_sweep;

  assign wr_dw       = DW_W'(lowest_dw(16'(rd_mod)));
  assign line_done   = only_bit_left(16'(rd_mod), 4'(wr_dw));
  assign op_is_sweep = (op_q == OP_HOLD_SWEEP) || (op_q == OP_FLUSH);

  always_comb begin
    state_d  = state_q;
    op_d     = op_q;
    inval_d  = inval_q;
    cur_d    = cur_slot;
    inv_en   = 1'b0;
    inv_slot = cur_slot;
    inv_all  = 1'b0;
    clr_en   = 1'b0;
    wr_req   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (inq_strobe && inq_hit) begin
          if (line_dirty[inq_slot]) begin
            state_d = ST_SNP_WAIT;
            op_d    = OP_SNOOP;
            inval_d = inq_inval;
            cur_d   = inq_slot;
          end else if (inq_inval) begin
            inv_en   = 1'b1;
            inv_slot = inq_slot;
          end
        end else if (bmw_valid && bmw_hit) begin
          inv_en   = 1'b1;
          inv_slot = bmw_slot;
        end else if (evict_req && !hold_req) begin
          if (line_dirty[evict_slot]) begin
            state_d = ST_WB_LINE;
            op_d    = OP_EVICT;
            inval_d = 1'b1;
            cur_d   = evict_slot;
          end else begin
            inv_en   = 1'b1;
            inv_slot = evict_slot;
          end
        end else if (flush_req && !hold_req) begin
          state_d = ST_SWEEP;
          op_d    = OP_FLUSH;
          inval_d = 1'b0;
          cur_d   = '0;
        end else if (sweep_start) begin
          state_d = ST_SWEEP;
          op_d    = OP_HOLD_SWEEP;
          inval_d = 1'b0;
          cur_d   = '0;
        end
      end
      ST_SNP_WAIT: begin
        if (!hold_req) state_d = ST_WB_LINE;
      end
      ST_WB_LINE: begin
        wr_req = 1'b1;
        if (wr_ack) begin
          clr_en = 1'b1;
          if (line_done) begin
            inv_en  = inval_q;
            state_d = op_is_sweep ? ST_SWEEP : ST_IDLE;
          end
        end
      end
      ST_SWEEP: begin
        if (line_dirty[cur_slot]) begin
          state_d = ST_WB_LINE;
        end else if (cur_slot == LAST_SLOT) begin
          inv_all = (op_q == OP_FLUSH);
          state_d = ST_IDLE;
        end else begin
          cur_d = cur_slot + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_SNOOP;
      inval_q  <= 1'b0;
      cur_slot <= '0;
    end else begin
      state_q  <= state_d;
      op_q     <= op_d;
      inval_q  <= inval_d;
      cur_slot <= cur_d;
    end
  end

  assign clr_dw   = wr_dw;
  assign seq_idle = (state_q == ST_IDLE);
  assign busy     = !seq_idle;
  assign hit_mod  = (state_q == ST_SNP_WAIT) ||
                    ((state_q == ST_WB_LINE) && (op_q == OP_SNOOP));

  // R4: hit-modified only ever starts from an inquiry on a modified line
  p_hitm_origin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_mod) |-> $past(inq_strobe && inq_hit && line_dirty[inq_slot]));

  // R5: snoop writeback never overlaps a live hold request
  p_snoop_wb_after_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && hit_mod) |-> !hold_req);

  // R3: a miss or a clean hit leaves the sequencer idle
  p_clean_inquiry_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_idle && inq_strobe && !(inq_hit && line_dirty[inq_slot])) |=> seq_idle);

  // R7: a snooped bus-master write never starts a writeback
  p_bmw_no_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_idle && !inq_strobe && bmw_valid && bmw_hit) |=> seq_idle);

endmodule

// File: rtl/cdt_snoop_ctrl.sv
module cdt_snoop_ctrl #(
  parameter int LINES  = 8,
  parameter int DWS    = 4,
  parameter int SLOT_W = $clog2(LINES),
  parameter int DW_W   = $clog2(DWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cw_valid,
  input  logic [SLOT_W-1:0] cw_slot,
  input  logic [DWS-1:0]    cw_mask,
  input  logic              fill_valid,
  input  logic [SLOT_W-1:0] fill_slot,
  input  logic              inq_strobe,
  input  logic              inq_inval,
  input  logic              inq_hit,
  input  logic [SLOT_W-1:0] inq_slot,
  input  logic              bmw_valid,
  input  logic              bmw_hit,
  input  logic [SLOT_W-1:0] bmw_slot,
  input  logic              evict_req,
  input  logic [SLOT_W-1:0] evict_slot,
  input  logic              flush_req,
  input  logic              fbg_mode,
  input  logic              hold_req,
  output logic              hold_ack,
  output logic              hit_mod,
  output logic              wr_req,
  output logic [SLOT_W-1:0] wr_slot,
  output logic [DW_W-1:0]   wr_dw,
  input  logic              wr_ack,
  output logic              busy,
  input  logic [SLOT_W-1:0] qry_slot,
  output logic              qry_valid,
  output logic [DWS-1:0]    qry_mod
);

  logic              seq_idle;
  logic              sweep_start;
  logic              any_dirty;
  logic [LINES-1:0]  line_dirty;
  logic [DWS-1:0]    rd_mod;
  logic [SLOT_W-1:0] cur_slot;
  logic              inv_en, inv_all, clr_en;
  logic [SLOT_W-1:0] inv_slot;
  logic [DW_W-1:0]   clr_dw;
  logic              core_wr_en, core_fill_en;

  // Core-side updates are only taken while no sequence runs.
  assign core_wr_en   = cw_valid   && seq_idle;
  assign core_fill_en = fill_valid && seq_idle;
  assign wr_slot      = cur_slot;

  cdt_line_state #(.LINES(LINES), .DWS(DWS), .SLOT_W(SLOT_W), .DW_W(DW_W)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .cw_en      (core_wr_en),
    .cw_slot    (cw_slot),
    .cw_mask    (cw_mask),
    .fill_en    (core_fill_en),
    .fill_slot  (fill_slot),
    .inv_en     (inv_en),
    .inv_slot   (inv_slot),
    .inv_all    (inv_all),
    .clr_en     (clr_en),
    .clr_slot   (cur_slot),
    .clr_dw     (clr_dw),
    .rd_slot    (cur_slot),
    .rd_mod     (rd_mod),
    .qry_slot   (qry_slot),
    .qry_valid  (qry_valid),
    .qry_mod    (qry_mod),
    .line_dirty (line_dirty),
    .any_dirty  (any_dirty)
  );

  cdt_hold_arb u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold_req    (hold_req),
    .fbg_mode    (fbg_mode),
    .seq_idle    (seq_idle),
    .any_dirty   (any_dirty),
    .hold_ack    (hold_ack),
    .sweep_start (sweep_start)
  );

  cdt_wb_seq #(.LINES(LINES), .DWS(DWS), .SLOT_W(SLOT_W), .DW_W(DW_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .inq_strobe  (inq_strobe),
    .inq_inval   (inq_inval),
    .inq_hit     (inq_hit),
    .inq_slot    (inq_slot),
    .bmw_valid   (bmw_valid),
    .bmw_hit     (bmw_hit),
    .bmw_slot    (bmw_slot),
    .evict_req   (evict_req),
    .evict_slot  (evict_slot),
    .flush_req   (flush_req),
    .hold_req    (hold_req),
    .sweep_start (sweep_start),
    .line_dirty  (line_dirty),
    .rd_mod      (rd_mod),
    .wr_ack      (wr_ack),
    .seq_idle    (seq_idle),
    .cur_slot    (cur_slot),
    .inv_en      (inv_en),
    .inv_slot    (inv_slot),
    .inv_all     (inv_all),
    .clr_en      (clr_en),
    .clr_dw      (clr_dw),
    .wr_req      (wr_req),
    .wr_dw       (wr_dw),
    .hit_mod     (hit_mod),
    .busy        (busy)
  );

  // R8: the memory bus is never written while it is granted away
  p_no_write_under_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> !hold_ack);

  // R11: core updates are blocked for the whole of a sequence
  p_core_blocked_when_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(core_wr_en || core_fill_en));

endmodule

// File: tb/tb_cdt_snoop_ctrl.sv
module tb_cdt_snoop_ctrl;

  localparam int LINES  = 8;
  localparam int DWS    = 4;
  localparam int SLOT_W = 3;
  localparam int DW_W   = 2;

  // Each entry: slot[10:8], store mask[7:4], expected flags afterwards[3:0]
  localparam logic [10:0] VEC [7] = '{
    11'b000_0001_0001,
    11'b000_0100_0101,
    11'b011_1000_1000,
    11'b011_0011_1011,
    11'b111_1111_1111,
    11'b101_0000_0000,
    11'b000_0001_0101
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cw_valid = 0, fill_valid = 0, inq_strobe = 0, inq_inval = 0, inq_hit = 0;
  logic bmw_valid = 0, bmw_hit = 0, evict_req = 0, flush_req = 0, fbg_mode = 0, hold_req = 0;
  logic wr_ack = 0;
  logic [SLOT_W-1:0] cw_slot = 0, fill_slot = 0, inq_slot = 0, bmw_slot = 0, evict_slot = 0, qry_slot = 0;
  logic [DWS-1:0] cw_mask = 0;
  logic hold_ack, hit_mod, wr_req, busy, qry_valid;
  logic [SLOT_W-1:0] wr_slot;
  logic [DW_W-1:0] wr_dw;
  logic [DWS-1:0] qry_mod;

  int checks = 0;
  int errors = 0;
  int log_n = 0;
  int log_slot [64];
  int log_dw [64];
  logic ack_slow = 0;
  logic ack_skip = 0;

  always #10 clk = ~clk;

  cdt_snoop_ctrl #(.LINES(LINES), .DWS(DWS)) dut (
    .clk(clk), .rst_n(rst_n),
    .cw_valid(cw_valid), .cw_slot(cw_slot), .cw_mask(cw_mask),
    .fill_valid(fill_valid), .fill_slot(fill_slot),
    .inq_strobe(inq_strobe), .inq_inval(inq_inval), .inq_hit(inq_hit), .inq_slot(inq_slot),
    .bmw_valid(bmw_valid), .bmw_hit(bmw_hit), .bmw_slot(bmw_slot),
    .evict_req(evict_req), .evict_slot(evict_slot), .flush_req(flush_req),
    .fbg_mode(fbg_mode), .hold_req(hold_req), .hold_ack(hold_ack), .hit_mod(hit_mod),
    .wr_req(wr_req), .wr_slot(wr_slot), .wr_dw(wr_dw), .wr_ack(wr_ack),
    .busy(busy), .qry_slot(qry_slot), .qry_valid(qry_valid), .qry_mod(qry_mod)
  );

  // Memory model: acknowledge a pending write, optionally every other cycle.
  always @(negedge clk) begin
    if (wr_req && !(ack_slow && ack_skip)) begin
      wr_ack = 1'b1;
      if (log_n < 64) begin
        log_slot[log_n] = int'(wr_slot);
        log_dw[log_n] = int'(wr_dw);
      end
      log_n = log_n + 1;
    end else begin
      wr_ack = 1'b0;
    end
    if (ack_slow) ack_skip = !ack_skip;
  end

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic line_state(input int slot, output int v, output int m);
    qry_slot = SLOT_W'(slot);
    #1;
    v = int'(qry_valid);
    m = int'(qry_mod);
  endtask

  task automatic check_line(input string tag, input int slot, input int ev, input int em);
    int v, m;
    line_state(slot, v, m);
    check_eq({tag, " valid"}, v, ev);
    check_eq({tag, " flags"}, m, em);
  endtask

  task automatic do_fill(input int slot);
    fill_valid = 1; fill_slot = SLOT_W'(slot);
    tick();
    fill_valid = 0;
  endtask

  task automatic do_store(input int slot, input int mask);
    cw_valid = 1; cw_slot = SLOT_W'(slot); cw_mask = DWS'(mask);
    tick();
    cw_valid = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    tick();
    while (busy && n < 2000) begin
      tick();
      n++;
    end
    check_eq("sequence finishes", int'(busy), 0);
  endtask

  task automatic check_log(input string tag, input int idx, input int slot, input int dw);
    check_eq({tag, " write slot"}, log_slot[idx], slot);
    check_eq({tag, " write dw"}, log_dw[idx], dw);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v, m;
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R12: reset state
    check_eq("R12 busy", int'(busy), 0);
    check_eq("R12 hold_ack", int'(hold_ack), 0);
    check_eq("R12 hit_mod", int'(hit_mod), 0);
    check_eq("R12 wr_req", int'(wr_req), 0);
    check_line("R12 line 2", 2, 0, 0);

    // R1: store to an invalid line is dropped
    do_store(6, 4'b1111);
    check_line("R1 store to invalid", 6, 0, 0);
    for (int s = 0; s < LINES; s++) do_fill(s);
    check_line("R1 fill clean", 6, 1, 0);

    // R1: table of stores and accumulated flags
    for (int i = 0; i < 7; i++) begin
      do_store(int'(VEC[i][10:8]), int'(VEC[i][7:4]));
      check_line("R1 store table", int'(VEC[i][10:8]), 1, int'(VEC[i][3:0]));
    end

    // R3: miss with invalidate touches nothing
    inq_strobe = 1; inq_hit = 0; inq_slot = 0; inq_inval = 1;
    tick();
    inq_strobe = 0;
    check_eq("R3 miss busy", int'(busy), 0);
    check_eq("R3 miss hit_mod", int'(hit_mod), 0);
    check_line("R3 miss keeps line", 0, 1, 5);
    // R3: clean hit with invalidate
    inq_strobe = 1; inq_hit = 1; inq_slot = 1; inq_inval = 1;
    tick();
    inq_strobe = 0;
    check_eq("R3 clean hit busy", int'(busy), 0);
    check_eq("R3 clean hit wr_req", int'(wr_req), 0);
    check_line("R3 clean hit invalidated", 1, 0, 0);

    // R4/R5/R6/R8: snoop on modified line 0, no invalidate
    log_n = 0;
    hold_req = 1;
    tick();
    check_eq("R8 grant next cycle", int'(hold_ack), 1);
    inq_strobe = 1; inq_hit = 1; inq_slot = 0; inq_inval = 0;
    tick();
    inq_strobe = 0;
    check_eq("R4 hit_mod raised", int'(hit_mod), 1);
    repeat (3) tick();
    check_eq("R5 no write under hold", int'(wr_req), 0);
    check_eq("R4 hit_mod held", int'(hit_mod), 1);
    hold_req = 0;
    tick();
    check_eq("R8 grant dropped", int'(hold_ack), 0);
    check_eq("R5 write after release", int'(wr_req), 1);
    wait_idle();
    check_eq("R2 write count", log_n, 2);
    check_log("R2 line0", 0, 0, 0);
    check_log("R2 line0", 1, 0, 2);
    check_eq("R4 hit_mod cleared", int'(hit_mod), 0);
    check_line("R6 kept clean", 0, 1, 0);

    // R6/R2: snoop with invalidate on line 3, slow memory
    log_n = 0; ack_slow = 1;
    hold_req = 1;
    tick();
    inq_strobe = 1; inq_hit = 1; inq_slot = 3; inq_inval = 1;
    tick();
    inq_strobe = 0;
    hold_req = 0;
    wait_idle();
    ack_slow = 0;
    check_eq("R2 write count slow", log_n, 3);
    check_log("R2 line3", 0, 3, 0);
    check_log("R2 line3", 1, 3, 1);
    check_log("R2 line3", 2, 3, 3);
    check_line("R6 invalidated", 3, 0, 0);

    // R7: bus-master write on modified line 7
    log_n = 0;
    hold_req = 1;
    tick();
    bmw_valid = 1; bmw_hit = 1; bmw_slot = 7;
    tick();
    bmw_valid = 0;
    check_eq("R7 no write", int'(wr_req), 0);
    check_line("R7 discarded", 7, 0, 0);
    hold_req = 0;
    repeat (3) tick();
    check_eq("R7 no writes logged", log_n, 0);

    // R8: flush-before-grant
    do_fill(3); do_fill(7);
    do_store(3, 4'b0110); do_store(7, 4'b1000); do_store(5, 4'b0001);
    log_n = 0; fbg_mode = 1; hold_req = 1;
    begin
      int n = 0;
      int early = 0;
      tick();
      while (!hold_ack && n < 500) begin
        if (wr_req && hold_ack) early++;
        tick();
        n++;
      end
      if (log_n < 4) early++;
      check_eq("R8 grant after last write", early, 0);
      check_eq("R8 grant given", int'(hold_ack), 1);
    end
    check_eq("R8 sweep count", log_n, 4);
    check_log("R8 sweep", 0, 3, 1);
    check_log("R8 sweep", 1, 3, 2);
    check_log("R8 sweep", 2, 5, 0);
    check_log("R8 sweep", 3, 7, 3);
    check_line("R8 line3 clean", 3, 1, 0);
    check_line("R8 line7 clean", 7, 1, 0);
    hold_req = 0; fbg_mode = 0;
    tick(); tick();

    // R10/R11: evict dirty line 2, store presented while busy
    do_store(2, 4'b1001);
    log_n = 0; ack_slow = 1;
    evict_req = 1; evict_slot = 2;
    tick();
    evict_req = 0;
    check_eq("R11 busy during evict", int'(busy), 1);
    cw_valid = 1; cw_slot = 6; cw_mask = 4'b1111;
    fill_valid = 1; fill_slot = 1;
    tick();
    cw_valid = 0; fill_valid = 0;
    wait_idle();
    ack_slow = 0;
    check_eq("R10 evict count", log_n, 2);
    check_log("R10 evict", 0, 2, 0);
    check_log("R10 evict", 1, 2, 3);
    check_line("R10 evicted", 2, 0, 0);
    check_line("R11 store ignored", 6, 1, 0);
    check_line("R11 fill ignored", 1, 0, 0);
    // R10: clean eviction
    evict_req = 1; evict_slot = 4;
    tick();
    evict_req = 0;
    check_eq("R10 clean evict idle", int'(busy), 0);
    check_line("R10 clean evicted", 4, 0, 0);

    // R9: flush
    do_store(0, 4'b0010); do_store(6, 4'b0100);
    log_n = 0;
    qry_slot = 0;
    flush_req = 1;
    tick();
    flush_req = 0;
    begin
      int n = 0;
      int bad = 0;
      while (busy && n < 2000) begin
        #1;
        if (wr_req && !qry_valid) bad++;
        tick();
        n++;
      end
      check_eq("R9 no early invalidate", bad, 0);
    end
    check_eq("R9 flush count", log_n, 2);
    check_log("R9 flush", 0, 0, 1);
    check_log("R9 flush", 1, 6, 2);
    check_line("R9 line0 gone", 0, 0, 0);
    check_line("R9 line6 gone", 6, 0, 0);
    check_line("R9 line5 gone", 5, 0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule